// File: doc/BRIEF.md
# Predicated Vector Element Sequencer

This block expands one scalar add instruction into a run of element operations, one per clock. Ordinary register numbers are given vector meaning by two per-register lookup tables held outside the block. A redirection table says whether each architectural register stands for a vector and, if so, which physical register starts it. A predicate table is kept separately for integer and floating-point operations. It names an integer register whose bits enable or disable individual elements.

A start pulse carries the destination and two source register numbers, the int/fp flag, a requested element count and an immediate limit. In that same cycle the block reads the predicate register through a dedicated read port. It then walks the elements. For each element it drives two operand read addresses and one register-file write with the sum. Masked-off elements still take their cycle, but the write stays off. A one-cycle done pulse ends every instruction. It comes with an error flag if the predicate entry selects the reserved bank.

Top module: `vec_elem_seq`

## Requirements
- R1: Predicate entries are 8 bits per architectural register (entry n at bits 8n+7..8n): bit 7 enable, bit 6 bank, bit 5 invert, bits 4..0 register index. When the entry used has enable 0, every element in the run writes.
- R2: The predicate read address driven during the start cycle is the entry's index plus its bank bit shifted left by 5, so bank 1 with index i gives address 32+i.
- R3: An enabled predicate entry with bank 1 is reserved. The instruction ends with done and err high together in the cycle after start, and no write is made.
- R4: With invert set, the element mask is the bitwise complement of the predicate register; otherwise it is the register value itself.
- R5: Floating-point instructions take their predicate entry from the fp table and integer instructions from the int table. In both cases the mask bits are read from the integer register file.
- R6: The predicate entry is selected by the destination's architectural number, not by the physical register it is redirected to.
- R7: Redirection entries are 7 bits per register (entry n at bits 7n+6..7n): bit 6 marks a vector, bits 5..0 give its base. A vector operand uses that base; a scalar operand uses its own register number.
- R8: Element e of a vector operand addresses base+e (modulo 64). A scalar operand keeps the same address for every element.
- R9: Element e is issued e+1 cycles after the start edge, one element per cycle with busy high. The write enable equals mask bit e, and the write data is the sum of the two operand read values.
- R10: The element count is the smallest of 63, the immediate limit and the requested count.
- R11: With an element count of 0, done is raised in the cycle after start, err stays low and nothing is written.
- R12: After the last element, done is high for exactly one cycle and busy is low. The block then returns to idle.
- R13: During and right after reset, busy, done, err and the write enable are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (taken only when idle) |
| is_fp | input | 1 | Selects the floating-point predicate table |
| rd | input | 5 | Destination architectural register |
| rs1 | input | 5 | First source architectural register |
| rs2 | input | 5 | Second source architectural register |
| vl_req | input | CNTW | Requested element count |
| vl_imm | input | VLW | Immediate element limit |
| vec_tbl | input | 32*7 | Redirection table |
| int_pred_tbl | input | 32*8 | Integer predicate table |
| fp_pred_tbl | input | 32*8 | Floating-point predicate table |
| mask_raddr | output | 6 | Predicate register read address (start cycle) |
| mask_rdata | input | XLEN | Predicate register read data |
| src1_raddr | output | 6 | First operand read address |
| src1_rdata | input | XLEN | First operand read data |
| src2_raddr | output | 6 | Second operand read address |
| src2_rdata | input | XLEN | Second operand read data |
| rf_wen | output | 1 | Element write enable |
| rf_waddr | output | 6 | Element write address |
| rf_wdata | output | XLEN | Element write data |
| busy | output | 1 | Elements are being issued |
| done | output | 1 | One-cycle end-of-instruction pulse |
| err | output | 1 | Reserved bank selected (with done) |

## Verification
The bench fills every table entry other than the ones under test with a decoy predicate that points at an all-zero register. A design that picks the wrong table, or that looks up the predicate after redirecting rd, then loses all its writes. Mask patterns with gaps, and an inverted mask, expose an off-by-one in element indexing or a missing complement as writes at the wrong element. Counts of 0 reached through the register and through the immediate, and a 63-element run, catch clamping that ignores one limit or hangs on zero. A reserved-bank case checks that the error ends the instruction at once instead of writing through register 32 and up.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
   localparam int ARCH_BITS = 5;
   localparam int NARCH     = 1 << ARCH_BITS;
   localparam int PHYS_BITS = ARCH_BITS + 1;

   typedef struct packed {
      logic                 en;
      logic                 bank;
      logic                 inv;
      logic [ARCH_BITS-1:0] idx;
   } pred_ent_t;

   typedef struct packed {
      logic                 is_vec;
      logic [PHYS_BITS-1:0] base;
   } vec_ent_t;

   localparam int PRED_W = $bits(pred_ent_t);
   localparam int VEC_W  = $bits(vec_ent_t);

   typedef enum logic [1:0] {
      SEQ_IDLE,
      SEQ_RUN,
      SEQ_DONE
   } seq_state_t;
endpackage

// File: rtl/vseq_vl_clamp.sv
module vseq_vl_clamp #(
   parameter int MAXVL = 63,
   parameter int CNTW  = 16,
   parameter int IMMW  = 6,
   parameter int VLW   = 6
) (
   input  logic [CNTW-1:0] req,
   input  logic [IMMW-1:0] imm,
   output logic [VLW-1:0]  vl
);
   if (CNTW < VLW) begin : g_bad_cntw
      $error("vseq_vl_clamp: CNTW narrower than VLW");
   end

   logic [CNTW-1:0] lim;

   always_comb begin
      lim = CNTW'(MAXVL);
      if (CNTW'(imm) < lim) lim = CNTW'(imm);
      if (req < lim)        lim = req;
   end

   assign vl = VLW'(lim);
endmodule

// File: rtl/vseq_pred_lookup.sv
module vseq_pred_lookup
   import vseq_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic                    is_fp,
   input  logic [ARCH_BITS-1:0]    rd_num,
   input  logic [NARCH*PRED_W-1:0] int_tbl,
   input  logic [NARCH*PRED_W-1:0] fp_tbl,
   output logic [PHYS_BITS-1:0]    mask_raddr,
   input  logic [XLEN-1:0]         mask_rdata,
   output logic [XLEN-1:0]         mask,
   output logic                    bank_rsvd
);
   pred_ent_t ent;

   always_comb begin
      if (is_fp) ent = pred_ent_t'(fp_tbl[rd_num*PRED_W +: PRED_W]);
      else       ent = pred_ent_t'(int_tbl[rd_num*PRED_W +: PRED_W]);
      mask_raddr = PHYS_BITS'(ent.idx) + (PHYS_BITS'(ent.bank) << ARCH_BITS);
      if (!ent.en)     mask = '1;
      else if (ent.inv) mask = ~mask_rdata;
      else             mask = mask_rdata;
      bank_rsvd = ent.en && ent.bank;
   end
endmodule

// File: rtl/vseq_redirect.sv
module vseq_redirect
   import vseq_pkg::*;
(
   input  logic [ARCH_BITS-1:0]   reg_num,
   input  logic [NARCH*VEC_W-1:0] tbl,
   output logic                   is_vec,
   output logic [PHYS_BITS-1:0]   phys
);
   vec_ent_t ent;

   assign ent    = vec_ent_t'(tbl[reg_num*VEC_W +: VEC_W]);
   assign is_vec = ent.is_vec;
   assign phys   = ent.is_vec ? ent.base : PHYS_BITS'(reg_num);
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
   import vseq_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int MAXVL = 63,
   parameter int CNTW  = 16,
   localparam int VLW  = $clog2(MAXVL + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic                    is_fp,
   input  logic [ARCH_BITS-1:0]    rd,
   input  logic [ARCH_BITS-1:0]    rs1,
   input  logic [ARCH_BITS-1:0]    rs2,
   input  logic [CNTW-1:0]         vl_req,
   input  logic [VLW-1:0]          vl_imm,
   input  logic [NARCH*VEC_W-1:0]  vec_tbl,
   input  logic [NARCH*PRED_W-1:0] int_pred_tbl,
   input  logic [NARCH*PRED_W-1:0] fp_pred_tbl,
   output logic [PHYS_BITS-1:0]    mask_raddr,
   input  logic [XLEN-1:0]         mask_rdata,
   output logic [PHYS_BITS-1:0]    src1_raddr,
   input  logic [XLEN-1:0]         src1_rdata,
   output logic [PHYS_BITS-1:0]    src2_raddr,
   input  logic [XLEN-1:0]         src2_rdata,
   output logic                    rf_wen,
   output logic [PHYS_BITS-1:0]    rf_waddr,
   output logic [XLEN-1:0]         rf_wdata,
   output logic                    busy,
   output logic                    done,
   output logic                    err
);
   localparam int NOPS = 3;   // 0: destination, 1: source 1, 2: source 2

   if (MAXVL > XLEN) begin : g_bad_maxvl
      $error("vec_elem_seq: MAXVL exceeds mask width XLEN");
   end
   if (MAXVL < 1) begin : g_bad_min
      $error("vec_elem_seq: MAXVL must be at least 1");
   end

   // Operand lookup, combinational from the start fields
   logic [NOPS-1:0][ARCH_BITS-1:0] arch_num;
   logic [NOPS-1:0]                op_vec;
   logic [NOPS-1:0][PHYS_BITS-1:0] op_base;

   assign arch_num = {rs2, rs1, rd};

   for (genvar g = 0; g < NOPS; g++) begin : g_redir
      vseq_redirect u_redir (
         .reg_num (arch_num[g]),
         .tbl     (vec_tbl),
         .is_vec  (op_vec[g]),
         .phys    (op_base[g])
      );
   end

   logic [XLEN-1:0] mask_new;
   logic            bank_rsvd;

   // Predicate is looked up from the architectural rd, before redirection
   vseq_pred_lookup #(.XLEN(XLEN)) u_pred (
      .is_fp      (is_fp),
      .rd_num     (rd),
      .int_tbl    (int_pred_tbl),
      .fp_tbl     (fp_pred_tbl),
      .mask_raddr (mask_raddr),
      .mask_rdata (mask_rdata),
      .mask       (mask_new),
      .bank_rsvd  (bank_rsvd)
   );

   logic [VLW-1:0] vl_new;

   vseq_vl_clamp #(
      .MAXVL (MAXVL),
      .CNTW  (CNTW),
      .IMMW  (VLW),
      .VLW   (VLW)
   ) u_clamp (
      .req (vl_req),
      .imm (vl_imm),
      .vl  (vl_new)
   );

   // Sequencer state
   seq_state_t                     state_q;
   logic [NOPS-1:0]                vec_q;
   logic [NOPS-1:0][PHYS_BITS-1:0] base_q;
   logic [XLEN-1:0]                mask_q;
   logic [VLW-1:0]                 vl_q;
   logic [VLW-1:0]                 idx_q;
   logic                           err_q;
   logic                           accept;

   assign accept = start && (state_q == SEQ_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         vec_q   <= '0;
         base_q  <= '0;
         mask_q  <= '0;
         vl_q    <= '0;
         idx_q   <= '0;
         err_q   <= 1'b0;
      end else begin
         case (state_q)
            SEQ_IDLE: begin
               if (accept) begin
                  vec_q  <= op_vec;
                  base_q <= op_base;
                  mask_q <= mask_new;
                  vl_q   <= vl_new;
                  idx_q  <= '0;
                  err_q  <= bank_rsvd;
                  if (bank_rsvd || (vl_new == '0)) state_q <= SEQ_DONE;
                  else                             state_q <= SEQ_RUN;
               end
            end
            SEQ_RUN: begin
               if (idx_q == vl_q - VLW'(1)) state_q <= SEQ_DONE;
               else                         idx_q   <= idx_q + VLW'(1);
            end
            SEQ_DONE: begin
               state_q <= SEQ_IDLE;
               err_q   <= 1'b0;
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   // Per-operand element address: vectors advance, scalars stay put
   logic [NOPS-1:0][PHYS_BITS-1:0] elem_addr;

   for (genvar g = 0; g < NOPS; g++) begin : g_addr
      assign elem_addr[g] = base_q[g] + (vec_q[g] ? PHYS_BITS'(idx_q) : '0);
   end

   assign rf_waddr   = elem_addr[0];
   assign src1_raddr = elem_addr[1];
   assign src2_raddr = elem_addr[2];

   assign busy     = (state_q == SEQ_RUN);
   assign done     = (state_q == SEQ_DONE);
   assign err      = done && err_q;
   assign rf_wen   = busy && mask_q[idx_q];
   assign rf_wdata = src1_rdata + src2_rdata;
endmodule

// File: rtl/vseq_checker.sv
module vseq_checker (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic busy,
   input logic done,
   input logic err,
   input logic rf_wen,
   input logic bank_rsvd,
   input logic vl_zero
);
   logic idle;
   assign idle = !busy && !done;

   AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !rf_wen); // R9

   AST_RUN_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      (start && idle && !bank_rsvd && !vl_zero) |=> busy); // R9

   AST_RSVD_ENDS_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (start && idle && bank_rsvd) |=> (done && err && !rf_wen)); // R3

   AST_ERR_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done); // R3

   AST_ZERO_COUNT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (start && idle && !bank_rsvd && vl_zero) |=> (done && !err && !busy)); // R11

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R12

   AST_BUSY_ENDS_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done); // R12

   AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done)); // R12
endmodule

bind vec_elem_seq vseq_checker u_vseq_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .err       (err),
   .rf_wen    (rf_wen),
   .bank_rsvd (bank_rsvd),
   .vl_zero   (vl_new == '0)
);

// File: tb/vec_elem_seq_test.sv
module vec_elem_seq_test;
   import vseq_pkg::*;

   localparam int XLEN  = 64;
   localparam int MAXVL = 63;
   localparam int CNTW  = 16;
   localparam int VLW   = 6;

   typedef struct packed {
      logic        fp;
      logic [4:0]  rd;   logic vd; logic [5:0] bd;
      logic [4:0]  rs1;  logic v1; logic [5:0] b1;
      logic [4:0]  rs2;  logic v2; logic [5:0] b2;
      logic        en;   logic bank; logic [4:0] pidx; logic inv;
      logic [63:0] pmask;
      logic [15:0] req;
      logic [5:0]  imm;
   } tv_t;

   function automatic tv_t mk(input logic fp,
      input logic [4:0] rd, input logic vd, input logic [5:0] bd,
      input logic [4:0] rs1, input logic v1, input logic [5:0] b1,
      input logic [4:0] rs2, input logic v2, input logic [5:0] b2,
      input logic en, input logic bank, input logic [4:0] pidx, input logic inv,
      input logic [63:0] pmask, input logic [15:0] req, input logic [5:0] imm);
      tv_t t;
      t.fp = fp; t.rd = rd; t.vd = vd; t.bd = bd;
      t.rs1 = rs1; t.v1 = v1; t.b1 = b1;
      t.rs2 = rs2; t.v2 = v2; t.b2 = b2;
      t.en = en; t.bank = bank; t.pidx = pidx; t.inv = inv;
      t.pmask = pmask; t.req = req; t.imm = imm;
      return t;
   endfunction

   localparam int NCASE = 8;
   localparam tv_t CASES [NCASE] = '{
      // int, no predicate, count limited by request (R1 R10)
      mk(1'b0, 5'd5, 1'b1, 6'd40, 5'd6, 1'b1, 6'd10, 5'd7, 1'b0, 6'd0,
         1'b0, 1'b0, 5'd0, 1'b0, 64'h0, 16'd4, 6'd8),
      // int, gapped mask, all vectors, rd redirected onto a decoy entry (R6)
      mk(1'b0, 5'd4, 1'b1, 6'd20, 5'd8, 1'b1, 6'd16, 5'd9, 1'b1, 6'd24,
         1'b1, 1'b0, 5'd2, 1'b0, 64'hA6, 16'd20, 6'd8),
      // fp table, inverted mask (R4 R5)
      mk(1'b1, 5'd1, 1'b1, 6'd50, 5'd2, 1'b0, 6'd0, 5'd12, 1'b1, 6'd20,
         1'b1, 1'b0, 5'd3, 1'b1, 64'hFFFF_FFFF_FFFF_FF0C, 16'd6, 6'd10),
      // scalar rd, count limited by immediate (R8 R10)
      mk(1'b0, 5'd11, 1'b0, 6'd0, 5'd13, 1'b1, 6'd8, 5'd14, 1'b0, 6'd0,
         1'b1, 1'b0, 5'd29, 1'b0, 64'h3, 16'd3, 6'd2),
      // reserved bank (R3)
      mk(1'b0, 5'd3, 1'b0, 6'd0, 5'd4, 1'b0, 6'd0, 5'd5, 1'b0, 6'd0,
         1'b1, 1'b1, 5'd2, 1'b0, 64'h0, 16'd5, 6'd5),
      // zero count from request (R11)
      mk(1'b0, 5'd2, 1'b0, 6'd0, 5'd3, 1'b0, 6'd0, 5'd4, 1'b0, 6'd0,
         1'b0, 1'b0, 5'd0, 1'b0, 64'h0, 16'd0, 6'd7),
      // zero count from immediate, fp (R11)
      mk(1'b1, 5'd6, 1'b0, 6'd0, 5'd7, 1'b0, 6'd0, 5'd8, 1'b0, 6'd0,
         1'b0, 1'b0, 5'd0, 1'b0, 64'h0, 16'd9, 6'd0),
      // full-length run, clamped to 63 (R10)
      mk(1'b1, 5'd15, 1'b1, 6'd0, 5'd16, 1'b0, 6'd0, 5'd17, 1'b0, 6'd0,
         1'b0, 1'b0, 5'd0, 1'b0, 64'h0, 16'd200, 6'd63)
   };

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic                    rst_n, start, is_fp;
   logic [4:0]              rd, rs1, rs2;
   logic [CNTW-1:0]         vl_req;
   logic [VLW-1:0]          vl_imm;
   logic [NARCH*VEC_W-1:0]  vec_tbl;
   logic [NARCH*PRED_W-1:0] int_pred_tbl, fp_pred_tbl;
   logic [5:0]              mask_raddr, src1_raddr, src2_raddr, rf_waddr;
   logic [XLEN-1:0]         mask_rdata, src1_rdata, src2_rdata, rf_wdata;
   logic                    rf_wen, busy, done, err;

   logic [XLEN-1:0] rf [64];
   logic            tb_we;
   logic [5:0]      tb_wa;
   logic [XLEN-1:0] tb_wd;

   always @(posedge clk) begin
      if (rf_wen)     rf[rf_waddr] <= rf_wdata;
      else if (tb_we) rf[tb_wa]    <= tb_wd;
   end
   assign mask_rdata = rf[mask_raddr];
   assign src1_rdata = rf[src1_raddr];
   assign src2_rdata = rf[src2_raddr];

   vec_elem_seq #(.XLEN(XLEN), .MAXVL(MAXVL), .CNTW(CNTW)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .is_fp(is_fp),
      .rd(rd), .rs1(rs1), .rs2(rs2), .vl_req(vl_req), .vl_imm(vl_imm),
      .vec_tbl(vec_tbl), .int_pred_tbl(int_pred_tbl), .fp_pred_tbl(fp_pred_tbl),
      .mask_raddr(mask_raddr), .mask_rdata(mask_rdata),
      .src1_raddr(src1_raddr), .src1_rdata(src1_rdata),
      .src2_raddr(src2_raddr), .src2_rdata(src2_rdata),
      .rf_wen(rf_wen), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
      .busy(busy), .done(done), .err(err)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic run_case(input tv_t t, input int n);
      logic [63:0] m;
      int          vl;
      logic [5:0]  ea0, ea1, ea2;
      // environment: fresh register contents, decoy predicate in reg 31
      @(negedge clk);
      tb_we = 1'b1;
      for (int k = 0; k < 64; k++) begin
         tb_wa = 6'(k);
         tb_wd = 64'(k) * 64'h0000_0100_0000_0011 + 64'd5;
         @(negedge clk);
      end
      tb_wa = 6'd31; tb_wd = 64'h0;
      @(negedge clk);
      if (t.en && !t.bank) begin
         tb_wa = {1'b0, t.pidx}; tb_wd = t.pmask;
         @(negedge clk);
      end
      tb_we = 1'b0;
      // tables: every predicate entry is an enabled decoy -> reg 31 (all zero)
      for (int k = 0; k < NARCH; k++) begin
         int_pred_tbl[k*PRED_W +: PRED_W] = 8'h9F;
         fp_pred_tbl[k*PRED_W +: PRED_W]  = 8'h9F;
      end
      vec_tbl = '0;
      if (t.fp) fp_pred_tbl[t.rd*PRED_W +: PRED_W]  = {t.en, t.bank, t.inv, t.pidx};
      else      int_pred_tbl[t.rd*PRED_W +: PRED_W] = {t.en, t.bank, t.inv, t.pidx};
      vec_tbl[t.rd*VEC_W +: VEC_W]  = {t.vd, t.bd};
      vec_tbl[t.rs1*VEC_W +: VEC_W] = {t.v1, t.b1};
      vec_tbl[t.rs2*VEC_W +: VEC_W] = {t.v2, t.b2};
      // expected count and mask from the requirements
      vl = MAXVL;
      if (int'(t.imm) < vl) vl = int'(t.imm);
      if (int'(t.req) < vl) vl = int'(t.req);
      m = !t.en ? '1 : (t.inv ? ~t.pmask : t.pmask);
      // issue
      is_fp = t.fp; rd = t.rd; rs1 = t.rs1; rs2 = t.rs2;
      vl_req = t.req; vl_imm = t.imm; start = 1'b1;
      #1;
      if (t.en) chk("R2", $sformatf("case %0d predicate address", n),
                    64'(mask_raddr), 64'({t.bank, t.pidx}));
      @(negedge clk);
      start = 1'b0;
      if (t.en && t.bank) begin
         chk("R3", $sformatf("case %0d done", n), 64'(done), 64'd1);
         chk("R3", $sformatf("case %0d err", n), 64'(err), 64'd1);
         chk("R3", $sformatf("case %0d write", n), 64'(rf_wen), 64'd0);
         @(negedge clk);
         return;
      end
      if (vl == 0) begin
         chk("R11", $sformatf("case %0d done", n), 64'(done), 64'd1);
         chk("R11", $sformatf("case %0d err/busy/write", n),
             64'({err, busy, rf_wen}), 64'd0);
         @(negedge clk);
         return;
      end
      for (int e = 0; e < vl; e++) begin
         ea0 = t.vd ? 6'(int'(t.bd) + e) : {1'b0, t.rd};
         ea1 = t.v1 ? 6'(int'(t.b1) + e) : {1'b0, t.rs1};
         ea2 = t.v2 ? 6'(int'(t.b2) + e) : {1'b0, t.rs2};
         chk("R12", $sformatf("case %0d el %0d busy", n, e), 64'(busy), 64'd1);
         chk("R9 R1 R4 R5 R6", $sformatf("case %0d el %0d wen", n, e),
             64'(rf_wen), 64'(m[e]));
         chk("R7 R8", $sformatf("case %0d el %0d src1 addr", n, e),
             64'(src1_raddr), 64'(ea1));
         chk("R7 R8", $sformatf("case %0d el %0d src2 addr", n, e),
             64'(src2_raddr), 64'(ea2));
         if (m[e]) begin
            chk("R7 R8", $sformatf("case %0d el %0d write addr", n, e),
                64'(rf_waddr), 64'(ea0));
            chk("R9", $sformatf("case %0d el %0d write data", n, e),
                rf_wdata, rf[ea1] + rf[ea2]);
         end
         @(negedge clk);
      end
      chk("R10 R12", $sformatf("case %0d done after %0d elements", n, vl),
          64'({done, busy, err, rf_wen}), 64'b1000);
      @(negedge clk);
      chk("R12", $sformatf("case %0d idle after done", n),
          64'({done, busy}), 64'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; start = 1'b0; is_fp = 1'b0;
      rd = '0; rs1 = '0; rs2 = '0; vl_req = '0; vl_imm = '0;
      vec_tbl = '0; int_pred_tbl = '0; fp_pred_tbl = '0;
      tb_we = 1'b0; tb_wa = '0; tb_wd = '0;
      repeat (3) @(negedge clk);
      chk("R13", "outputs in reset", 64'({busy, done, err, rf_wen}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R13", "outputs after reset", 64'({busy, done, err, rf_wen}), 64'd0);
      for (int c = 0; c < NCASE; c++) run_case(CASES[c], c);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule